// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Arbiter

This block decides when a 256-row DRAM gets refreshed. It also decides which of two requesters, the refresh engine or the processor, may start the next memory cycle. An interval timer paces the requests. A pending flag holds each request until the DRAM sequencer is told to run a refresh cycle. A row counter supplies the row address and steps once per refresh cycle.

The block has two pacing schemes, selected by an input pin:
- **Spread mode** refreshes one row per slot. The slot is shortened slightly so that the worst-case service delay, summed over all rows, still fits inside the retention period.
- **Burst mode** refreshes all rows back to back once per retention period. The processor is locked out for the whole sweep, and the rest of the period is free of refresh.

The timer runs freely, whatever happens to the requests it raises. A request that is still waiting when the next one falls due sets a sticky overrun flag.

The integrator sets the clock rate (kHz) and the retention period (µs) as parameters. All timer limits are derived from these two values at elaboration.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ref_req`, `ref_grant` and `overrun` are 0 and `ref_row` is 0. The interval timer also restarts from 0.
- R2: With `burst_mode`=0 the timer period is P = S − ceil(S·4/ROWS) clocks, where S = floor(CLK_KHZ·RETENTION_US/1000/ROWS). `ref_req` first rises P clocks after reset is released. Later rises are exactly P clocks apart, however quickly each request is served.
- R3: A raised request stays asserted until it is granted. In spread mode, `ref_req` falls on the same clock edge that raises `ref_grant`.
- R4: `ref_grant` is a one-clock pulse. It is raised on the clock after any cycle in which a request is pending, `access_busy` is 0 and no refresh cycle is in progress. With processor accesses of at most 4 clocks, the grant arrives 1 to 5 clocks after the request.
- R5: While `access_busy` is 1, no `ref_grant` is issued on the following clock edge.
- R6: `cpu_grant` is 1 exactly when `cpu_req` is 1, `ref_req` is 0 and no refresh cycle is in progress. A refresh cycle is in progress from the `ref_grant` edge up to and including the cycle carrying `row_strobe`. `cpu_grant` and `ref_grant` are never 1 together.
- R7: Each clock with `row_strobe`=1 advances `ref_row` by one, modulo ROWS.
- R8: `overrun` becomes 1 when a timer expiry arrives while a spread-mode request is still waiting ungranted, or while a burst is still running. Once set, it stays 1 until reset.
- R9: With `burst_mode`=1 the timer period is CLK_KHZ·RETENTION_US/1000 clocks. On expiry `ref_row` is cleared to 0 and `ref_req` is held high across ROWS refresh cycles. `ref_req` falls when the strobe that wraps `ref_row` back to 0 is taken.
- R10: During a burst, `cpu_grant` stays 0 even when `cpu_req` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_mode | input | 1 | 1 selects burst pacing, 0 selects spread pacing |
| cpu_req | input | 1 | Processor asks to start a memory access |
| access_busy | input | 1 | A processor access is in progress |
| row_strobe | input | 1 | Row-select strobe of the running refresh cycle |
| ref_req | output | 1 | Refresh request outstanding (or burst running) |
| ref_grant | output | 1 | One-clock pulse: sequencer shall run a refresh cycle |
| cpu_grant | output | 1 | Processor may start its access this cycle |
| ref_row | output | $clog2(ROWS) | Row address for the refresh cycle |
| overrun | output | 1 | Sticky: a refresh fell due before the previous was served |

## Verification
The assertions assume the following about the environment:
- `row_strobe` comes exactly once for each `ref_grant` and only while that refresh cycle is in progress.
- `access_busy` rises only on the clock after a `cpu_grant` and lasts at most four clocks.
- `burst_mode` changes only while no request is outstanding.

The stimulus respects these assumptions as follows:
- A responder model raises the strobe 1 to 3 clocks after each grant.
- A processor model requests at random and, once granted, holds `access_busy` for 1 to 4 clocks.
- The mode is switched only in a cycle where `ref_req` is low.

A single directed phase holds `access_busy` high on purpose, to force an overrun. During that phase the latency checks are switched off.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  // Clocks in one retention period.
  function automatic longint unsigned retention_cycles(
    input longint unsigned clk_khz, input longint unsigned ret_us);
    return (clk_khz * ret_us) / 64'd1000;
  endfunction

  // Clocks in one evenly spread row slot.
  function automatic longint unsigned slot_cycles(
    input longint unsigned clk_khz, input longint unsigned ret_us,
    input longint unsigned rows);
    return retention_cycles(clk_khz, ret_us) / rows;
  endfunction

  // Spread-mode period: slot minus a rounded-up share of the latency margin.
  function automatic longint unsigned spread_period(
    input longint unsigned clk_khz, input longint unsigned ret_us,
    input longint unsigned rows, input longint unsigned margin);
    longint unsigned s;
    s = slot_cycles(clk_khz, ret_us, rows);
    return s - ((s * margin + rows - 1) / rows);
  endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import dram_refresh_pkg::*;
#(
  parameter int unsigned      CNT_W   = 20,
  parameter longint unsigned  SPREAD_P = 100,
  parameter longint unsigned  BURST_P  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  output logic tick
);
  localparam logic [CNT_W-1:0] SPREAD_LAST = CNT_W'(SPREAD_P - 1);
  localparam logic [CNT_W-1:0] BURST_LAST  = CNT_W'(BURST_P - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = burst_mode ? BURST_LAST : SPREAD_LAST;
  // ">=" keeps the timer bounded if the mode shortens the period mid-count.
  assign tick = (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2: reload straight after expiry, independent of any servicing.
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
  // R2: otherwise the timer only counts up by one.
  assert_free_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_strobe,
  input  logic             row_clear,
  output logic [ROW_W-1:0] row,
  output logic             row_wrap
);
  localparam logic [ROW_W-1:0] ROW_TOP = '1;

  assign row_wrap = row_strobe && !row_clear && (row == ROW_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)          row <= '0;
    else if (row_clear)  row <= '0;
    else if (row_strobe) row <= row + 1'b1;
  end

  // R7: one row per strobe.
  assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe && !row_clear) |=> (row == $past(row) + 1'b1));
  // R9: burst start puts the counter back at row zero.
  assert_row_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_clear |=> (row == '0));
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic burst_mode,
  input  logic cpu_req,
  input  logic access_busy,
  input  logic row_strobe,
  input  logic row_wrap,
  output logic row_clear,
  output logic ref_req,
  output logic ref_grant,
  output logic cpu_grant,
  output logic overrun
);
  logic pending;
  logic active;
  logic burst_on;

  // Named events, visible to the assertions.
  logic grant_ok;
  logic overrun_evt;
  logic burst_rearm;

  assign grant_ok    = pending && !access_busy && !active;
  assign row_clear   = tick && burst_mode;
  assign burst_rearm = burst_on && row_strobe && !row_wrap;
  assign overrun_evt = tick && ((pending && !grant_ok) || burst_on);

  assign ref_req   = pending || burst_on;
  assign cpu_grant = cpu_req && !ref_req && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      active    <= 1'b0;
      burst_on  <= 1'b0;
      overrun   <= 1'b0;
      ref_grant <= 1'b0;
    end else begin
      ref_grant <= grant_ok;

      if (tick || burst_rearm) pending <= 1'b1;
      else if (grant_ok)       pending <= 1'b0;

      if (grant_ok)        active <= 1'b1;
      else if (row_strobe) active <= 1'b0;

      if (row_clear)     burst_on <= 1'b1;
      else if (row_wrap) burst_on <= 1'b0;

      if (overrun_evt) overrun <= 1'b1;
    end
  end

  assert_grant_prompt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ok |=> ref_grant);
  assert_grant_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |=> !ref_grant);
  assert_wait_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    access_busy |=> !ref_grant);
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> ref_grant);
  assert_one_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_grant, ref_grant}));
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && !row_wrap) |=> (ref_req && !cpu_grant));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 250000,
  parameter int unsigned RETENTION_US = 4000,
  parameter int unsigned ROWS         = 256,
  parameter int unsigned LAT_MARGIN   = 4,
  localparam int unsigned ROW_W       = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_mode,
  input  logic             cpu_req,
  input  logic             access_busy,
  input  logic             row_strobe,
  output logic             ref_req,
  output logic             ref_grant,
  output logic             cpu_grant,
  output logic [ROW_W-1:0] ref_row,
  output logic             overrun
);
  localparam longint unsigned BURST_P  = retention_cycles(CLK_KHZ, RETENTION_US);
  localparam longint unsigned SPREAD_P = spread_period(CLK_KHZ, RETENTION_US, ROWS, LAT_MARGIN);
  localparam int unsigned     CNT_W    = $clog2(BURST_P + 1);

  logic tick;
  logic row_clear;
  logic row_wrap;

  refresh_interval_timer #(
    .CNT_W(CNT_W), .SPREAD_P(SPREAD_P), .BURST_P(BURST_P)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .tick(tick)
  );

  refresh_row_counter #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .row_strobe(row_strobe), .row_clear(row_clear),
    .row(ref_row), .row_wrap(row_wrap)
  );

  refresh_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .burst_mode(burst_mode),
    .cpu_req(cpu_req), .access_busy(access_busy), .row_strobe(row_strobe),
    .row_wrap(row_wrap), .row_clear(row_clear), .ref_req(ref_req),
    .ref_grant(ref_grant), .cpu_grant(cpu_grant), .overrun(overrun)
  );

  initial begin
    assert_params_R2: assert (SPREAD_P >= 2 && (1 << ROW_W) == ROWS);
  end
endmodule

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
  localparam int KHZ = 1000, RUS = 4000, ROWS = 256, MARG = 4;

  function automatic int exp_burst();
    return (KHZ / 10) * (RUS / 100);
  endfunction
  function automatic int exp_spread();
    int s;
    s = exp_burst() / ROWS;
    return s - ((s * MARG + ROWS - 1) >> 8);
  endfunction
  localparam int P_SPREAD = exp_spread();
  localparam int P_BURST  = exp_burst();

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, burst_mode = 1'b0, cpu_req = 1'b0, access_busy = 1'b0, row_strobe = 1'b0;
  logic ref_req, ref_grant, cpu_grant, overrun;
  logic [7:0] ref_row;

  dram_refresh_sched #(.CLK_KHZ(KHZ), .RETENTION_US(RUS), .ROWS(ROWS), .LAT_MARGIN(MARG)) dut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .cpu_req(cpu_req),
    .access_busy(access_busy), .row_strobe(row_strobe), .ref_req(ref_req),
    .ref_grant(ref_grant), .cpu_grant(cpu_grant), .ref_row(ref_row), .overrun(overrun));

  int checks = 0, fails = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  bit force_busy = 0, spread_chk = 0, lat_chk = 0, burst_phase = 0;
  int cyc, last_rise, wait_start, busy_cnt, resp_delay, exp_row;
  int burst_strobes, burst_done, last_burst_rise, force_age;
  bit strobe_wait, outstanding, prev_req, prev_grant, seen_first;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; last_rise = 0; wait_start = 0; busy_cnt = 0; resp_delay = 0;
      exp_row = 0; burst_strobes = 0; burst_done = 0; last_burst_rise = 0; force_age = 0;
      strobe_wait = 0; outstanding = 0; prev_req = 0; prev_grant = 0; seen_first = 0;
      cpu_req = 0; access_busy = 0; row_strobe = 0;
    end else begin
      cyc++;
      if (row_strobe) begin
        exp_row = (exp_row + 1) % ROWS;
        chk(ref_row == exp_row, "R7 row step", ref_row, exp_row);
        outstanding = 0;
        if (burst_mode) begin burst_strobes++; wait_start = cyc; end
        row_strobe = 0;
      end
      if (prev_grant) chk(!ref_grant, "R4 pulse width", ref_grant, 0);
      if (ref_grant) begin
        if (lat_chk)
          chk(cyc - wait_start >= 1 && cyc - wait_start <= 5, "R4 latency", cyc - wait_start, 5);
        outstanding = 1; strobe_wait = 1; resp_delay = $urandom_range(0, 2);
      end
      if (ref_req && !prev_req) begin
        wait_start = cyc;
        if (burst_mode) begin
          chk(ref_row == 0, "R9 row cleared", ref_row, 0);
          exp_row = 0; burst_strobes = 0;
          if (last_burst_rise > 0)
            chk(cyc - last_burst_rise == P_BURST, "R9 period", cyc - last_burst_rise, P_BURST);
          last_burst_rise = cyc;
        end else if (spread_chk) begin
          if (!seen_first) chk(cyc == P_SPREAD, "R2 first request", cyc, P_SPREAD);
          else chk(cyc - last_rise == P_SPREAD, "R2 interval", cyc - last_rise, P_SPREAD);
          last_rise = cyc;
        end
        seen_first = 1;
      end
      if (!ref_req && prev_req) begin
        if (burst_mode) begin
          chk(burst_strobes == ROWS, "R9 burst length", burst_strobes, ROWS);
          chk(ref_row == 0, "R9 wrap to zero", ref_row, 0);
          burst_done++;
        end else chk(ref_grant, "R3 held until grant", ref_grant, 1);
      end
      if (cpu_grant)
        chk(!ref_req && !ref_grant && !outstanding, "R6 exclusive", {ref_req, ref_grant, outstanding}, 0);
      else if (cpu_req && !ref_req && !outstanding)
        chk(0, "R6 grant when idle", 0, 1);
      if (burst_mode && ref_req && cpu_req) chk(!cpu_grant, "R10 burst blocks cpu", cpu_grant, 0);
      force_age = force_busy ? force_age + 1 : 0;
      if (force_age >= 3) chk(!ref_grant, "R5 busy blocks grant", ref_grant, 0);
      if (strobe_wait) begin
        if (resp_delay == 0) begin row_strobe = 1; strobe_wait = 0; end
        else resp_delay--;
      end
      if (busy_cnt > 0) busy_cnt--;
      if (cpu_grant && cpu_req && busy_cnt == 0 && !force_busy) busy_cnt = $urandom_range(1, 4);
      access_busy = force_busy || (busy_cnt > 0);
      cpu_req = (busy_cnt == 0) && !force_busy && ($urandom_range(0, 1) == 1);
      prev_req = ref_req; prev_grant = ref_grant;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic reset_check(input string phase);
    chk(!ref_req && !ref_grant && !cpu_grant, {"R1 idle outputs ", phase},
        {ref_req, ref_grant, cpu_grant}, 0);
    chk(ref_row == 0, {"R1 row ", phase}, ref_row, 0);
    chk(!overrun, {"R1 overrun ", phase}, overrun, 0);
  endtask

  initial begin
    int seed;
    bit got;
    seed = $urandom(20240611);
    repeat (4) @(negedge clk);
    reset_check("first");
    #1 rst_n = 1; spread_chk = 1; lat_chk = 1;
    repeat (600) @(negedge clk);
    chk(!overrun, "R8 no false overrun", overrun, 0);
    #1 lat_chk = 0; spread_chk = 0; force_busy = 1;
    repeat (40) @(negedge clk);
    chk(overrun, "R8 overrun set", overrun, 1);
    chk(ref_req, "R3 request held while busy", ref_req, 1);
    #1 force_busy = 0;
    got = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ref_grant) got = 1;
    end
    chk(got, "R4 grant after access ends", got, 1);
    repeat (30) @(negedge clk);
    chk(overrun, "R8 overrun sticky", overrun, 1);
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    reset_check("second");
    #1 rst_n = 1; spread_chk = 1; lat_chk = 1;
    repeat (300) @(negedge clk);
    while (ref_req) @(negedge clk);
    #1 burst_mode = 1; spread_chk = 0; burst_phase = 1;
    while (burst_done < 2) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!overrun, "R8 no overrun in burst", overrun, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule